// File: doc/BRIEF.md
# EPR4 Maximum-Likelihood Sequence Detector

This block recovers the recorded bit stream from equalized read-channel samples. The samples are shaped to the extended class-4 partial-response target 1 + D - D^2 - D^3. The detector accepts one signed sample per clock, qualified by a valid strobe. It first scales each sample by a programmable factor near unity. It then runs an eight-state add-compare-select trellis and keeps a fixed-depth register-exchange survivor memory. For every accepted sample, once the memory is full, it emits one decided bit.

Each decided bit carries a margin flag. The flag marks decisions where the two paths competing for a state were closer than a programmable threshold. Stress tests use it to count weak decisions without a separate error reference. The upstream converter, the equalizer, timing recovery and the line coding are outside this block.

Top module: `epr4_vd`

## Requirements
- R1: After reset, `bit_valid_o`, `bit_o` and `margin_o` are 0. Path metric 0 is assigned to the state with all three previous bits zero, and every other state starts at 16384 (`PM_INIT`).
- R2: The state is the last three decided bits, with bit 2 the most recent. Each input bit b maps to a = 2b-1, and the noiseless sample for a branch is 7·(a_n + a_{n-1} - a_{n-2} - a_{n-3}). A noiseless stream, starting from the all-zero history at unity gain, is decoded without error.
- R3: The scaled sample is floor(sample·(32+k)/32). Here k is the 4-bit two's-complement `gain_k_i`, clamped to the range -6..+6, so 7 acts as 6 and -8 acts as -6.
- R4: A branch metric is the square of (scaled sample minus branch target). Each state keeps the smaller of its two candidate sums, and on a tie it keeps the predecessor whose oldest history bit is 0. After every update the smallest path metric is 0 and all metrics stay below 2^(PM_W-1).
- R5: The output bit is the oldest bit (depth 16) of the survivor ending in the smallest-metric state, with the lowest state index winning ties. The decision for the n-th accepted sample appears, with `bit_valid_o` high, in the clock after the (n+15)-th accepted sample.
- R6: The first 15 accepted samples after reset produce no output (`bit_valid_o` stays 0).
- R7: `margin_o` accompanies an output bit. It is 1 when, at the step where that bit entered the winning path, |candidate0 - candidate1| at its state was below `margin_thr_i`. A threshold of 0 never flags, and `margin_o` is 0 whenever `bit_valid_o` is 0.
- R8: While `valid_i` is 0, no metric or survivor changes, and `bit_valid_o`, `bit_o` and `margin_o` are 0 in the following cycle. Idle gaps leave the decoded sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; trellis advances only when high |
| sample_i | input | SAMPLE_W (6) | Signed equalized sample |
| gain_k_i | input | K_W (4) | Signed gain step k, gain = 1 + k/32 |
| margin_thr_i | input | THR_W (8) | Metric-difference threshold for weak decisions |
| bit_valid_o | output | 1 | Decided bit present this cycle |
| bit_o | output | 1 | Decided bit |
| margin_o | output | 1 | Weak-decision flag for `bit_o` |

## Verification
On every clock, assertions check the following: path metrics stay bounded, and at least one metric is zero after normalization; the trellis state is frozen and the outputs are quiet after an idle cycle; the margin flag never appears without a decided bit.

The remaining behaviours depend on whole sequences, so only the bench's scenarios can show them. These are the actual bit decisions, their 15-sample lag, the gain scaling with its clamp, the tie rules and the margin flag values. The bench covers them with a behavioural trellis model and, for noiseless streams, a direct comparison against the transmitted bits.

// File: rtl/epr4_pkg.sv
package epr4_pkg;
  localparam int NUM_ST  = 8;
  localparam int NUM_LVL = 5;

  // noiseless level index -4..4 for a branch from prev into cur
  function automatic int branch_level(input logic [2:0] prev, input logic cur);
    int a0, a1, a2, a3;
    a0 = cur     ? 1 : -1;
    a1 = prev[2] ? 1 : -1;
    a2 = prev[1] ? 1 : -1;
    a3 = prev[0] ? 1 : -1;
    return a0 + a1 - a2 - a3;
  endfunction
endpackage

// File: rtl/epr4_gain.sv
module epr4_gain #(
  parameter int SAMPLE_W = 6,
  parameter int K_W      = 4,
  parameter int K_MAX    = 6,
  parameter int FRAC_W   = 5,
  parameter int Y_W      = SAMPLE_W + 1
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [K_W-1:0]      k_i,
  output logic signed [Y_W-1:0]      y_o
);
  localparam int P_W = SAMPLE_W + FRAC_W + 2;

  logic signed [K_W-1:0]      k_eff;
  logic signed [FRAC_W+1:0]   gain_f;
  logic signed [P_W-1:0]      prod;

  always_comb begin
    if (k_i > K_MAX)       k_eff = K_W'(K_MAX);
    else if (k_i < -K_MAX) k_eff = K_W'(-K_MAX);
    else                   k_eff = k_i;
  end

  assign gain_f = (FRAC_W+2)'(1 << FRAC_W) + {{(FRAC_W+2-K_W){k_eff[K_W-1]}}, k_eff};
  assign prod   = sample_i * gain_f;
  assign y_o    = Y_W'(prod >>> FRAC_W);  // floor
endmodule

// File: rtl/epr4_bmu.sv
module epr4_bmu #(
  parameter int Y_W     = 7,
  parameter int D_W     = 9,
  parameter int BM_W    = 18,
  parameter int UNIT    = 7,
  parameter int NUM_LVL = 5
) (
  input  logic signed [Y_W-1:0]          y_i,
  output logic [NUM_LVL-1:0][BM_W-1:0]   bm_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam int TGT = (2*l - (NUM_LVL-1)) * UNIT;
    logic signed [D_W-1:0]  d;
    logic signed [BM_W-1:0] d_sq;
    assign d       = D_W'(y_i) - D_W'(TGT);
    assign d_sq    = d * d;
    assign bm_o[l] = $unsigned(d_sq);
  end
endmodule

// File: rtl/epr4_acs.sv
module epr4_acs #(
  parameter int PM_W  = 16,
  parameter int BM_W  = 18,
  parameter int SUM_W = 19
) (
  input  logic [PM_W-1:0]  pm0_i,
  input  logic [PM_W-1:0]  pm1_i,
  input  logic [BM_W-1:0]  bm0_i,
  input  logic [BM_W-1:0]  bm1_i,
  output logic [SUM_W-1:0] cand_o,
  output logic             sel_o,
  output logic [SUM_W-1:0] diff_o
);
  logic [SUM_W-1:0] c0, c1;
  assign c0     = SUM_W'(pm0_i) + SUM_W'(bm0_i);
  assign c1     = SUM_W'(pm1_i) + SUM_W'(bm1_i);
  assign sel_o  = c1 < c0;  // tie keeps predecessor 0
  assign cand_o = sel_o ? c1 : c0;
  assign diff_o = sel_o ? (c0 - c1) : (c1 - c0);
endmodule

// File: rtl/epr4_vd.sv
module epr4_vd #(
  parameter int SAMPLE_W = 6,
  parameter int K_W      = 4,
  parameter int K_MAX    = 6,
  parameter int UNIT     = 7,
  parameter int DEPTH    = 16,
  parameter int PM_W     = 16,
  parameter int PM_INIT  = 16384,
  parameter int THR_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [K_W-1:0]      gain_k_i,
  input  logic [THR_W-1:0]           margin_thr_i,
  output logic                       bit_valid_o,
  output logic                       bit_o,
  output logic                       margin_o
);
  localparam int NUM_ST   = epr4_pkg::NUM_ST;
  localparam int NUM_LVL  = epr4_pkg::NUM_LVL;
  localparam int Y_W      = SAMPLE_W + 1;
  localparam int D_W      = Y_W + 2;
  localparam int BM_W     = 2 * D_W;
  localparam int SUM_W    = ((BM_W > PM_W) ? BM_W : PM_W) + 1;
  localparam int CNT_W    = $clog2(DEPTH);
  localparam int ST_W     = $clog2(NUM_ST);
  localparam int PM_LIMIT = 2 ** (PM_W - 1);

  logic signed [Y_W-1:0]              y;
  logic [NUM_LVL-1:0][BM_W-1:0]       bm;
  logic [NUM_ST-1:0][SUM_W-1:0]       cand, diff;
  logic [NUM_ST-1:0]                  sel;
  logic [NUM_ST-1:0][PM_W-1:0]        pm_q, pm_nx;
  logic [NUM_ST-1:0][DEPTH-2:0]       surv_q, mflag_q;
  logic [NUM_ST-1:0][DEPTH-1:0]       surv_nx, mflag_nx;
  logic [NUM_ST-1:0]                  pm_zero;
  logic [SUM_W-1:0]                   cand_min;
  logic [ST_W-1:0]                    best;
  logic [CNT_W-1:0]                   fill_cnt;
  logic                               filled;

  epr4_gain #(
    .SAMPLE_W(SAMPLE_W), .K_W(K_W), .K_MAX(K_MAX), .FRAC_W(5), .Y_W(Y_W)
  ) u_gain (
    .sample_i(sample_i), .k_i(gain_k_i), .y_o(y)
  );

  epr4_bmu #(
    .Y_W(Y_W), .D_W(D_W), .BM_W(BM_W), .UNIT(UNIT), .NUM_LVL(NUM_LVL)
  ) u_bmu (
    .y_i(y), .bm_o(bm)
  );

  for (genvar s = 0; s < NUM_ST; s++) begin : g_st
    localparam logic [2:0] ST  = 3'(s);
    localparam logic [2:0] P0  = {ST[1:0], 1'b0};
    localparam logic [2:0] P1  = {ST[1:0], 1'b1};
    localparam int         LV0 = (epr4_pkg::branch_level(P0, ST[2]) + 4) / 2;
    localparam int         LV1 = (epr4_pkg::branch_level(P1, ST[2]) + 4) / 2;

    epr4_acs #(.PM_W(PM_W), .BM_W(BM_W), .SUM_W(SUM_W)) u_acs (
      .pm0_i(pm_q[P0]), .pm1_i(pm_q[P1]),
      .bm0_i(bm[LV0]),  .bm1_i(bm[LV1]),
      .cand_o(cand[s]), .sel_o(sel[s]), .diff_o(diff[s])
    );

    assign surv_nx[s]  = {(sel[s] ? surv_q[P1] : surv_q[P0]), ST[2]};
    assign mflag_nx[s] = {(sel[s] ? mflag_q[P1] : mflag_q[P0]),
                          (diff[s] < SUM_W'(margin_thr_i))};
    assign pm_nx[s]    = PM_W'(cand[s] - cand_min);
    assign pm_zero[s]  = (pm_q[s] == '0);

    assert_pm_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pm_q[s] < PM_W'(PM_LIMIT));
  end

  always_comb begin
    cand_min = cand[0];
    best     = '0;
    for (int s = 1; s < NUM_ST; s++) begin
      if (cand[s] < cand_min) begin
        cand_min = cand[s];
        best     = ST_W'(s);
      end
    end
  end

  assign filled = (fill_cnt == CNT_W'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_ST; s++) pm_q[s] <= (s == 0) ? '0 : PM_W'(PM_INIT);
      surv_q      <= '0;
      mflag_q     <= '0;
      fill_cnt    <= '0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      margin_o    <= 1'b0;
    end else begin
      bit_valid_o <= valid_i && filled;
      bit_o       <= valid_i && filled && surv_nx[best][DEPTH-1];
      margin_o    <= valid_i && filled && mflag_nx[best][DEPTH-1];
      if (valid_i) begin
        pm_q <= pm_nx;
        for (int s = 0; s < NUM_ST; s++) begin
          surv_q[s]  <= surv_nx[s][DEPTH-2:0];
          mflag_q[s] <= mflag_nx[s][DEPTH-2:0];
        end
        if (!filled) fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  assert_min_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_zero != '0);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pm_q) && $stable(surv_q) && $stable(mflag_q)));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!bit_valid_o && !bit_o && !margin_o));
  assert_margin_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    margin_o |-> bit_valid_o);
endmodule

// File: tb/epr4_vd_tb_top.sv
`timescale 1ns/1ps
module epr4_vd_tb_top;
  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic signed [5:0] sample_i = '0;
  logic signed [3:0] gain_k_i = '0;
  logic [7:0]        margin_thr_i = '0;
  logic              bit_valid_o, bit_o, margin_o;

  always #2.5 clk = ~clk;

  epr4_vd dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .gain_k_i(gain_k_i), .margin_thr_i(margin_thr_i),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o), .margin_o(margin_o)
  );

  int total = 0, bad = 0;
  int mpm[8];
  logic [15:0] msurv[8], mmarg[8];
  int acc, hist, k_cur, thr_cur, seen_marg;
  int sent[0:2047];
  bit exp_v, exp_b, exp_m, exp_t_en, truth_en;
  int exp_t;
  string cur_tag;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic int amp(input int b);
    return b ? 1 : -1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      mpm[s] = (s == 0) ? 0 : 16384;
      msurv[s] = '0;
      mmarg[s] = '0;
    end
    acc = 0; hist = 0;
    exp_v = 0; exp_b = 0; exp_m = 0; exp_t_en = 0;
  endtask

  task automatic model_step(input int smp);
    int kk, p, y, np[8], best, c0, c1, lv0, lv1, pr, d;
    logic [15:0] ns_s[8], ns_m[8];
    kk = k_cur;
    if (kk > 6) kk = 6;
    if (kk < -6) kk = -6;
    p = smp * (32 + kk);
    y = (p >= 0) ? p / 32 : -((-p + 31) / 32);
    for (int st = 0; st < 8; st++) begin
      int b, q0, q1;
      b  = (st >> 2) & 1;
      q0 = (st & 3) << 1;
      q1 = q0 | 1;
      lv0 = (amp(b) + amp((q0 >> 2) & 1) - amp((q0 >> 1) & 1) - amp(q0 & 1)) * 7;
      lv1 = (amp(b) + amp((q1 >> 2) & 1) - amp((q1 >> 1) & 1) - amp(q1 & 1)) * 7;
      c0 = mpm[q0] + (y - lv0) * (y - lv0);
      c1 = mpm[q1] + (y - lv1) * (y - lv1);
      pr = (c1 < c0) ? q1 : q0;
      np[st] = (c1 < c0) ? c1 : c0;
      d = (c1 < c0) ? c0 - c1 : c1 - c0;
      ns_s[st] = {msurv[pr][14:0], 1'(b)};
      ns_m[st] = {mmarg[pr][14:0], 1'(d < thr_cur)};
    end
    best = 0;
    for (int st = 1; st < 8; st++) if (np[st] < np[best]) best = st;
    for (int st = 0; st < 8; st++) begin
      mpm[st] = np[st]; msurv[st] = ns_s[st]; mmarg[st] = ns_m[st];
    end
    acc++;
    exp_v = (acc >= 16);
    exp_b = exp_v && ns_s[best][15];
    exp_m = exp_v && ns_m[best][15];
    exp_t_en = exp_v && truth_en;
    exp_t = exp_v ? sent[acc-16] : 0;
  endtask

  task automatic tick(input bit v, input int smp);
    @(negedge clk);
    chk({cur_tag, " valid"}, bit_valid_o, exp_v);
    chk({cur_tag, " bit"}, bit_o, exp_b);
    chk({cur_tag, " margin"}, margin_o, exp_m);
    if (exp_t_en) chk("R2 truth", bit_o, exp_t);
    seen_marg += margin_o;
    valid_i = v;
    sample_i = 6'(smp);
    gain_k_i = 4'(k_cur);
    margin_thr_i = 8'(thr_cur);
    if (v) model_step(smp);
    else begin
      exp_v = 0; exp_b = 0; exp_m = 0; exp_t_en = 0;
    end
  endtask

  task automatic send(input int b, input int na);
    int s;
    s = (amp(b) + amp((hist >> 2) & 1) - amp((hist >> 1) & 1) - amp(hist & 1)) * 7;
    if (na > 0) s += int'($urandom_range(2 * na)) - na;
    if (s > 31) s = 31;
    if (s < -32) s = -32;
    sent[acc] = b;
    hist = ((b << 2) | (hist >> 1)) & 7;
    tick(1'b1, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 valid", bit_valid_o, 0);
    chk("R1 bit", bit_o, 0);
    chk("R1 margin", margin_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    k_cur = 0; thr_cur = 0; truth_en = 1; seen_marg = 0; cur_tag = "R1";
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // noiseless stream: fill gap then exact decode
    for (int i = 0; i < 200; i++) begin
      cur_tag = (i < 15) ? "R6" : "R2";
      send(int'($urandom_range(1)), 0);
    end

    // idle gaps inside the stream
    cur_tag = "R8";
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(2) == 0) tick(1'b0, 0);
      else send(int'($urandom_range(1)), 0);
    end

    // noisy with margin threshold
    truth_en = 0;
    cur_tag = "R7";
    k_cur = 2; thr_cur = 40;
    for (int i = 0; i < 200; i++) send(int'($urandom_range(1)), 5);

    // zero threshold never flags; metrics and ties under noise
    cur_tag = "R4";
    k_cur = -4; thr_cur = 0;
    for (int i = 0; i < 150; i++) begin
      if (i == 30) seen_marg = 0;
      send(int'($urandom_range(1)), 6);
    end
    chk("R7 zero threshold flags", seen_marg, 0);

    // gain clamp at both ends
    cur_tag = "R3";
    k_cur = 7; thr_cur = 60;
    for (int i = 0; i < 150; i++) send(int'($urandom_range(1)), 4);
    k_cur = -8;
    for (int i = 0; i < 150; i++) send(int'($urandom_range(1)), 4);

    // reset mid-run, fill again, latency
    k_cur = 0; thr_cur = 0; truth_en = 1;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      cur_tag = (i < 15) ? "R6" : "R5";
      send(int'($urandom_range(1)), 0);
    end
    tick(1'b0, 0);
    tick(1'b0, 0);

    report();
    $finish;
  end
endmodule